// File: doc/BRIEF.md
# SDRAM Command Protocol and Timing Monitor

This block watches the command pins of a single-rank SDRAM on every rising clock edge and reports the first command that breaks either the bank state rules or a minimum command spacing. It never drives the memory. For each bank it tracks whether the bank is idle, has an open row, or is closing after a column access with auto-precharge. It also keeps saturating cycle counters since the last activate and since the last precharge of that bank. Shared counters cover rules that span all banks: activate-to-activate spacing across banks, the quiet time after a mode register load, the refresh recovery time, and the length of an unbroken run of refreshes.

All timing limits are parameters expressed in clock cycles. An integrator converts nanosecond figures by rounding up to whole clocks. The burst length used for auto-precharge closing is also a parameter, and it must be at least 2. The first violation raises a sticky flag. It also stores a one-hot code naming the broken rule and the value of a free-running cycle counter at the offending command. These outputs hold until reset. `rst_n` is asserted asynchronously and must be released synchronously to `clk`.

Top module: `sdram_cmd_checker`

## Requirements
- R1: After reset `err_flag` is 0, `err_code` is 0 and `err_cycle` is 0.
- R2: A command is decoded only when `cke` was 1 at the previous edge and is 1 at the current edge and `cs_n` is 0. With {ras_n,cas_n,we_n}: 000 mode load, 001 refresh, 010 precharge (a10=1 means all banks), 011 activate, 100 write, 101 read, 110 burst stop, 111 no-op. Any other cycle is a no-op and raises no error.
- R3: An activate to a bank other than the one last activated, fewer than T_RRD cycles after that activate, sets code bit 7.
- R4: A read or write fewer than T_RCD cycles after its bank's activate sets bit 8. Column commands on consecutive cycles are legal.
- R5: A precharge, to one bank or to all banks, that closes a bank opened fewer than T_RAS cycles earlier sets bit 9.
- R6: An activate fewer than T_RP cycles after its bank was precharged sets bit 10.
- R7: An activate fewer than T_RC cycles after the same bank's previous activate sets bit 11.
- R8: A mode load or refresh while any bank is open or closing sets bit 3.
- R9: Any command fewer than T_MRD cycles after a mode load sets bit 4.
- R10: Any command fewer than T_RFC cycles after a refresh sets bit 5.
- R11: A read or write with a10=1 closes its bank after BURST_LEN cycles. Until then, a read, write or activate to that bank sets bit 2. The bank counts as precharged at the end of the burst, so R6 applies from that point.
- R12: A refresh that follows MAX_REF_RUN refreshes with no other command between them sets bit 6.
- R13: A read or write to a bank with no open row sets bit 0. An activate to a bank whose row is open sets bit 1.
- R14: Only the first erroneous command is recorded. If that command breaks several rules, only the lowest-numbered bit is set. `err_cycle` is the number of clock edges between reset release and that command's edge, counting from 0. Later errors change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| cke | input | 1 | Clock enable pin as seen at the memory |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| a10 | input | 1 | Auto-precharge / all-bank select address bit |
| ba | input | BA_W | Bank address |
| err_flag | output | 1 | Sticky violation flag |
| err_code | output | 12 | One-hot rule code of the first violation |
| err_cycle | output | CYC_W | Cycle count at the first violation |

## Verification
Several properties are checked on every cycle:
- Once raised, the flag never falls.
- While the flag is set, the code holds exactly one bit, and the code and cycle never change after they are captured.
- The flag rises only after some rule was broken in the previous cycle.
- A bank that finishes its auto-precharge countdown is found idle with its precharge counter restarted.
- A command directly after a mode load or a refresh is always reported.

Whether each limit sits at exactly the right cycle count can only be shown by the bench. It sweeps the gap between command pairs across each threshold, and it walks through the decode gating, the auto-precharge window, the refresh run limit and the priority between simultaneous violations.

// File: rtl/sdram_chk_pkg.sv
package sdram_chk_pkg;

  typedef enum logic [2:0] {
    OP_MRS = 3'b000,
    OP_REF = 3'b001,
    OP_PRE = 3'b010,
    OP_ACT = 3'b011,
    OP_WR  = 3'b100,
    OP_RD  = 3'b101,
    OP_BST = 3'b110,
    OP_NOP = 3'b111
  } sdram_op_e;

  localparam int ERR_N     = 12;
  localparam int E_IDLE    = 0;
  localparam int E_OPEN    = 1;
  localparam int E_APBUSY  = 2;
  localparam int E_MODEBSY = 3;
  localparam int E_MRD     = 4;
  localparam int E_RFC     = 5;
  localparam int E_REFRUN  = 6;
  localparam int E_RRD     = 7;
  localparam int E_RCD     = 8;
  localparam int E_RAS     = 9;
  localparam int E_RP      = 10;
  localparam int E_RC      = 11;

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_chk_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cke,
  input  logic      cs_n,
  input  logic      ras_n,
  input  logic      cas_n,
  input  logic      we_n,
  output logic      cmd_vld,
  output sdram_op_e op
);

  logic cke_q;
  logic cke_d;

  always_comb begin
    cke_d   = cke;
    op      = sdram_op_e'({ras_n, cas_n, we_n});
    cmd_vld = cke_q & cke & ~cs_n & (op != OP_NOP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_q <= 1'b0;
    end else begin
      cke_q <= cke_d;
    end
  end

endmodule

// File: rtl/sdram_bank_timer.sv
module sdram_bank_timer
  import sdram_chk_pkg::*;
#(
  parameter int AGE_W     = 4,
  parameter int AGE_MAX   = 10,
  parameter int T_RCD     = 3,
  parameter int T_RAS     = 6,
  parameter int T_RP      = 3,
  parameter int T_RC      = 10,
  parameter int BURST_LEN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_vld,
  input  sdram_op_e        op,
  input  logic             a10,
  input  logic             sel,
  output logic [ERR_N-1:0] viol,
  output logic             busy
);

  localparam int BLW = (BURST_LEN > 2) ? $clog2(BURST_LEN) : 1;
  localparam logic [AGE_W-1:0] LIM_RCD = AGE_W'(T_RCD);
  localparam logic [AGE_W-1:0] LIM_RAS = AGE_W'(T_RAS);
  localparam logic [AGE_W-1:0] LIM_RP  = AGE_W'(T_RP);
  localparam logic [AGE_W-1:0] LIM_RC  = AGE_W'(T_RC);
  localparam logic [AGE_W-1:0] SAT     = AGE_W'(AGE_MAX);
  localparam logic [BLW-1:0]   AP_INIT = BLW'(BURST_LEN - 1);

  logic             open_q,    open_d;
  logic [BLW-1:0]   ap_left_q, ap_left_d;
  logic [AGE_W-1:0] act_age_q, act_age_d;
  logic [AGE_W-1:0] pre_age_q, pre_age_d;

  logic closing, is_act, is_col, is_pre;

  always_comb begin
    closing = (ap_left_q != '0);
    is_act  = cmd_vld & sel & (op == OP_ACT);
    is_col  = cmd_vld & sel & ((op == OP_RD) | (op == OP_WR));
    is_pre  = cmd_vld & (op == OP_PRE) & (sel | a10);
    busy    = open_q | closing;
  end

  // violation detection
  always_comb begin
    viol = '0;
    if (is_col) begin
      if (closing)                  viol[E_APBUSY] = 1'b1;
      else if (!open_q)             viol[E_IDLE]   = 1'b1;
      else if (act_age_q < LIM_RCD) viol[E_RCD]    = 1'b1;
    end
    if (is_act) begin
      if (closing) begin
        viol[E_APBUSY] = 1'b1;
      end else begin
        if (open_q)               viol[E_OPEN] = 1'b1;
        if (pre_age_q < LIM_RP)   viol[E_RP]   = 1'b1;
        if (act_age_q < LIM_RC)   viol[E_RC]   = 1'b1;
      end
    end
    if (is_pre && open_q && (act_age_q < LIM_RAS)) viol[E_RAS] = 1'b1;
  end

  // next state
  always_comb begin
    open_d    = open_q;
    ap_left_d = closing ? (ap_left_q - 1'b1) : '0;
    act_age_d = (act_age_q == SAT) ? act_age_q : (act_age_q + 1'b1);
    pre_age_d = (pre_age_q == SAT) ? pre_age_q : (pre_age_q + 1'b1);
    if (closing && (ap_left_q == BLW'(1))) begin
      pre_age_d = '0;
    end
    if (is_act && !closing) begin
      open_d    = 1'b1;
      act_age_d = AGE_W'(1);
    end
    if (is_col && a10 && open_q) begin
      open_d    = 1'b0;
      ap_left_d = AP_INIT;
    end
    if (is_pre && open_q) begin
      open_d    = 1'b0;
      pre_age_d = AGE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q    <= 1'b0;
      ap_left_q <= '0;
      act_age_q <= SAT;
      pre_age_q <= SAT;
    end else begin
      open_q    <= open_d;
      ap_left_q <= ap_left_d;
      act_age_q <= act_age_d;
      pre_age_q <= pre_age_d;
    end
  end

  // R11
  ap_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(closing) |-> (!open_q && (pre_age_q == '0)));

endmodule

// File: rtl/sdram_global_timer.sv
module sdram_global_timer
  import sdram_chk_pkg::*;
#(
  parameter int BA_W        = 2,
  parameter int AGE_W       = 4,
  parameter int AGE_MAX     = 10,
  parameter int T_RRD       = 2,
  parameter int T_MRD       = 2,
  parameter int T_RFC       = 7,
  parameter int MAX_REF_RUN = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_vld,
  input  sdram_op_e        op,
  input  logic [BA_W-1:0]  ba,
  input  logic             any_busy,
  output logic [ERR_N-1:0] viol
);

  localparam int RUN_W = $clog2(MAX_REF_RUN + 1);
  localparam logic [AGE_W-1:0] LIM_RRD = AGE_W'(T_RRD);
  localparam logic [AGE_W-1:0] LIM_MRD = AGE_W'(T_MRD);
  localparam logic [AGE_W-1:0] LIM_RFC = AGE_W'(T_RFC);
  localparam logic [AGE_W-1:0] SAT     = AGE_W'(AGE_MAX);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(MAX_REF_RUN);

  logic [AGE_W-1:0] rrd_age_q, rrd_age_d;
  logic [AGE_W-1:0] mrs_age_q, mrs_age_d;
  logic [AGE_W-1:0] ref_age_q, ref_age_d;
  logic [BA_W-1:0]  last_ba_q, last_ba_d;
  logic [RUN_W-1:0] ref_run_q, ref_run_d;

  logic is_act, is_mrs, is_ref;

  always_comb begin
    is_act = cmd_vld & (op == OP_ACT);
    is_mrs = cmd_vld & (op == OP_MRS);
    is_ref = cmd_vld & (op == OP_REF);
  end

  always_comb begin
    viol = '0;
    if (cmd_vld && (mrs_age_q < LIM_MRD)) viol[E_MRD] = 1'b1;
    if (cmd_vld && (ref_age_q < LIM_RFC)) viol[E_RFC] = 1'b1;
    if (is_act && (ba != last_ba_q) && (rrd_age_q < LIM_RRD)) viol[E_RRD] = 1'b1;
    if ((is_mrs || is_ref) && any_busy) viol[E_MODEBSY] = 1'b1;
    if (is_ref && (ref_run_q == RUN_MAX)) viol[E_REFRUN] = 1'b1;
  end

  always_comb begin
    rrd_age_d = (rrd_age_q == SAT) ? rrd_age_q : (rrd_age_q + 1'b1);
    mrs_age_d = (mrs_age_q == SAT) ? mrs_age_q : (mrs_age_q + 1'b1);
    ref_age_d = (ref_age_q == SAT) ? ref_age_q : (ref_age_q + 1'b1);
    last_ba_d = last_ba_q;
    ref_run_d = ref_run_q;
    if (is_act) begin
      rrd_age_d = AGE_W'(1);
      last_ba_d = ba;
    end
    if (is_mrs) mrs_age_d = AGE_W'(1);
    if (is_ref) begin
      ref_age_d = AGE_W'(1);
      if (ref_run_q != RUN_MAX) ref_run_d = ref_run_q + 1'b1;
    end else if (cmd_vld) begin
      ref_run_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rrd_age_q <= SAT;
      mrs_age_q <= SAT;
      ref_age_q <= SAT;
      last_ba_q <= '0;
      ref_run_q <= '0;
    end else begin
      rrd_age_q <= rrd_age_d;
      mrs_age_q <= mrs_age_d;
      ref_age_q <= ref_age_d;
      last_ba_q <= last_ba_d;
      ref_run_q <= ref_run_d;
    end
  end

  generate
    if (T_MRD > 1) begin : g_mrd_chk
      // R9
      mrd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(is_mrs) && cmd_vld) |-> viol[E_MRD]);
    end
    if (T_RFC > 1) begin : g_rfc_chk
      // R10
      rfc_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(is_ref) && cmd_vld) |-> viol[E_RFC]);
    end
  endgenerate

endmodule

// File: rtl/sdram_err_log.sv
module sdram_err_log
  import sdram_chk_pkg::*;
#(
  parameter int CYC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ERR_N-1:0] viol,
  output logic             err_flag,
  output logic [ERR_N-1:0] err_code,
  output logic [CYC_W-1:0] err_cycle
);

  logic [CYC_W-1:0] cyc_q, cyc_d;
  logic             flag_q, flag_d;
  logic [ERR_N-1:0] code_q, code_d;
  logic [CYC_W-1:0] at_q, at_d;
  logic [ERR_N-1:0] lowest;
  logic             capture;

  always_comb begin
    lowest  = viol & (~viol + ERR_N'(1));
    capture = !flag_q && (viol != '0);
    cyc_d   = cyc_q + 1'b1;
    flag_d  = flag_q | capture;
    code_d  = capture ? lowest : code_q;
    at_d    = capture ? cyc_q  : at_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q  <= '0;
      flag_q <= 1'b0;
      code_q <= '0;
      at_q   <= '0;
    end else begin
      cyc_q  <= cyc_d;
      flag_q <= flag_d;
      if (capture) begin
        code_q <= code_d;
        at_q   <= at_d;
      end
    end
  end

  assign err_flag  = flag_q;
  assign err_code  = code_q;
  assign err_cycle = at_q;

  // R14
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q |=> flag_q);

  // R14
  code_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q |-> ($countones(code_q) == 1));

  // R14
  record_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q |=> ($stable(code_q) && $stable(at_q)));

  // R14
  flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> ($past(viol) != '0));

endmodule

// File: rtl/sdram_cmd_checker.sv
module sdram_cmd_checker
  import sdram_chk_pkg::*;
#(
  parameter int BA_W        = 2,
  parameter int T_RRD       = 2,
  parameter int T_RCD       = 3,
  parameter int T_RAS       = 6,
  parameter int T_RP        = 3,
  parameter int T_RC        = 10,
  parameter int T_RFC       = 7,
  parameter int T_MRD       = 2,
  parameter int BURST_LEN   = 4,
  parameter int MAX_REF_RUN = 8,
  parameter int CYC_W       = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke,
  input  logic             cs_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic             a10,
  input  logic [BA_W-1:0]  ba,
  output logic             err_flag,
  output logic [11:0]      err_code,
  output logic [CYC_W-1:0] err_cycle
);

  localparam int NBANK   = 2 ** BA_W;
  localparam int M0      = (T_RRD > T_RCD) ? T_RRD : T_RCD;
  localparam int M1      = (T_RAS > T_RP)  ? T_RAS : T_RP;
  localparam int M2      = (T_RC  > T_RFC) ? T_RC  : T_RFC;
  localparam int M3      = (M0 > M1) ? M0 : M1;
  localparam int M4      = (M2 > T_MRD) ? M2 : T_MRD;
  localparam int AGE_MAX = (M3 > M4) ? M3 : M4;
  localparam int AGE_W   = $clog2(AGE_MAX + 1);

  logic             cmd_vld;
  sdram_op_e        op;
  logic [ERR_N-1:0] bank_viol [NBANK];
  logic [NBANK-1:0] bank_busy;
  logic [ERR_N-1:0] glob_viol;
  logic [ERR_N-1:0] viol_all;

  sdram_cmd_decode u_decode (
    .clk     (clk),
    .rst_n   (rst_n),
    .cke     (cke),
    .cs_n    (cs_n),
    .ras_n   (ras_n),
    .cas_n   (cas_n),
    .we_n    (we_n),
    .cmd_vld (cmd_vld),
    .op      (op)
  );

  generate
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
      sdram_bank_timer #(
        .AGE_W     (AGE_W),
        .AGE_MAX   (AGE_MAX),
        .T_RCD     (T_RCD),
        .T_RAS     (T_RAS),
        .T_RP      (T_RP),
        .T_RC      (T_RC),
        .BURST_LEN (BURST_LEN)
      ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd_vld (cmd_vld),
        .op      (op),
        .a10     (a10),
        .sel     (ba == BA_W'(b)),
        .viol    (bank_viol[b]),
        .busy    (bank_busy[b])
      );
    end
  endgenerate

  sdram_global_timer #(
    .BA_W        (BA_W),
    .AGE_W       (AGE_W),
    .AGE_MAX     (AGE_MAX),
    .T_RRD       (T_RRD),
    .T_MRD       (T_MRD),
    .T_RFC       (T_RFC),
    .MAX_REF_RUN (MAX_REF_RUN)
  ) u_global (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_vld  (cmd_vld),
    .op       (op),
    .ba       (ba),
    .any_busy (|bank_busy),
    .viol     (glob_viol)
  );

  always_comb begin
    viol_all = glob_viol;
    for (int i = 0; i < NBANK; i++) begin
      viol_all = viol_all | bank_viol[i];
    end
  end

  sdram_err_log #(
    .CYC_W (CYC_W)
  ) u_log (
    .clk       (clk),
    .rst_n     (rst_n),
    .viol      (viol_all),
    .err_flag  (err_flag),
    .err_code  (err_code),
    .err_cycle (err_cycle)
  );

endmodule

// File: tb/sdram_cmd_checker_test.sv
module sdram_cmd_checker_test;

  localparam int CLK_PERIOD = 10;
  localparam int TRRD = 2, TRCD = 3, TRAS = 6, TRP = 3, TRC = 10;
  localparam int TRFC = 7, TMRD = 2, BL = 4, MAXREF = 8;

  localparam logic [2:0] C_MRS = 3'b000, C_REF = 3'b001, C_PRE = 3'b010, C_ACT = 3'b011;
  localparam logic [2:0] C_WR  = 3'b100, C_RD  = 3'b101, C_NOP = 3'b111;

  localparam int X_NONE = -1, X_IDLE = 0, X_OPEN = 1, X_AP = 2, X_MODE = 3, X_MRD = 4;
  localparam int X_RFC = 5, X_RUN = 6, X_RRD = 7, X_RCD = 8, X_RAS = 9, X_RP = 10, X_RC = 11;

  logic clk = 1'b0;
  logic rst_n, cke, cs_n, ras_n, cas_n, we_n, a10;
  logic [1:0]  ba;
  logic        err_flag;
  logic [11:0] err_code;
  logic [31:0] err_cycle;

  int n_chk = 0, n_fail = 0;
  int edges = 0, last_cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_cmd_checker uut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .a10(a10), .ba(ba),
    .err_flag(err_flag), .err_code(err_code), .err_cycle(err_cycle)
  );

  task automatic step(input logic [2:0] c, input int bank = 0, input logic ap = 1'b0,
                      input logic ck = 1'b1, input logic cs = 1'b0);
    cke = ck; cs_n = cs; {ras_n, cas_n, we_n} = c; ba = 2'(bank); a10 = ap;
    @(posedge clk);
    last_cyc = edges;
    edges++;
    @(negedge clk);
  endtask

  task automatic nops(input int n);
    for (int i = 0; i < n; i++) step(C_NOP);
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0; cke = 1'b1; cs_n = 1'b1; {ras_n, cas_n, we_n} = C_NOP; a10 = 1'b0; ba = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    edges = 0;
    step(C_NOP);
  endtask

  task automatic expect_rec(input string req, input int idx, input int cyc);
    logic        ef;
    logic [11:0] ec;
    ef = (idx >= 0);
    ec = (idx >= 0) ? 12'(1 << idx) : 12'h000;
    n_chk++;
    if (err_flag !== ef || err_code !== ec || (ef && err_cycle !== 32'(cyc))) begin
      n_fail++;
      $display("FAIL %s: flag=%0b code=%03h cycle=%0d, expected flag=%0b code=%03h cycle=%0d",
               req, err_flag, err_code, err_cycle, ef, ec, cyc);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int c0;
    rst_n = 1'b0; cke = 1'b1; cs_n = 1'b1; {ras_n, cas_n, we_n} = C_NOP; a10 = 1'b0; ba = '0;

    // R1: reset state
    @(negedge clk); @(negedge clk);
    n_chk++;
    if (err_flag !== 1'b0 || err_code !== 12'h0 || err_cycle !== 32'h0) begin
      n_fail++;
      $display("FAIL R1: flag=%0b code=%03h cycle=%0d, expected 0 0 0", err_flag, err_code, err_cycle);
    end

    // R2: gating by chip select and clock enable
    do_reset;
    step(C_RD, 0, 0, 1, 1);  expect_rec("R2 cs high", X_NONE, 0);
    step(C_NOP, 0, 0, 0, 0);
    step(C_RD, 0, 0, 1, 0);  expect_rec("R2 cke low before", X_NONE, 0);
    step(C_RD, 0, 0, 0, 0);  expect_rec("R2 cke low now", X_NONE, 0);
    step(C_NOP);
    step(C_RD);              expect_rec("R2 decoded", X_IDLE, last_cyc);

    // R3: activate spacing across banks
    for (int d = 1; d <= TRRD + 1; d++) begin
      do_reset;
      step(C_ACT, 0); nops(d - 1); step(C_ACT, 1);
      expect_rec("R3 rrd sweep", (d < TRRD) ? X_RRD : X_NONE, last_cyc);
    end

    // R4: activate to column spacing
    for (int d = 1; d <= TRCD + 1; d++) begin
      do_reset;
      step(C_ACT, 2); nops(d - 1); step(C_RD, 2);
      expect_rec("R4 rcd sweep", (d < TRCD) ? X_RCD : X_NONE, last_cyc);
    end
    do_reset;
    step(C_ACT, 1); nops(TRCD - 1);
    step(C_RD, 1); step(C_WR, 1); step(C_RD, 1); step(C_WR, 1);
    expect_rec("R4 back-to-back columns", X_NONE, 0);

    // R5: activate to precharge spacing
    for (int d = 1; d <= TRAS + 1; d++) begin
      do_reset;
      step(C_ACT, 0); nops(d - 1); step(C_PRE, 0);
      expect_rec("R5 ras sweep", (d < TRAS) ? X_RAS : X_NONE, last_cyc);
    end
    do_reset;
    step(C_ACT, 1); nops(1); step(C_PRE, 3, 1'b1);
    expect_rec("R5 all-bank precharge", X_RAS, last_cyc);

    // R6: precharge to activate spacing
    for (int d = 1; d <= TRP + 1; d++) begin
      do_reset;
      step(C_ACT, 0); nops(7); step(C_PRE, 0); nops(d - 1); step(C_ACT, 0);
      expect_rec("R6 rp sweep", (d < TRP) ? X_RP : X_NONE, last_cyc);
    end

    // R7: activate to activate, same bank
    for (int g = TRAS + TRP; g <= TRC; g++) begin
      do_reset;
      step(C_ACT, 3); nops(TRAS - 1); step(C_PRE, 3); nops(g - TRAS - 1); step(C_ACT, 3);
      expect_rec("R7 rc sweep", (g < TRC) ? X_RC : X_NONE, last_cyc);
    end

    // R8: mode load and refresh with a bank in use
    do_reset;
    step(C_ACT, 1); nops(3); step(C_MRS);
    expect_rec("R8 mode load with open bank", X_MODE, last_cyc);
    do_reset;
    step(C_ACT, 2); nops(3); step(C_REF);
    expect_rec("R8 refresh with open bank", X_MODE, last_cyc);

    // R9: quiet time after mode load
    for (int d = 1; d <= TMRD + 1; d++) begin
      do_reset;
      step(C_MRS); nops(d - 1); step(C_ACT, 0);
      expect_rec("R9 mrd sweep", (d < TMRD) ? X_MRD : X_NONE, last_cyc);
    end

    // R10: refresh recovery
    for (int d = 1; d <= TRFC + 1; d++) begin
      do_reset;
      step(C_REF); nops(d - 1); step(C_ACT, 1);
      expect_rec("R10 rfc sweep", (d < TRFC) ? X_RFC : X_NONE, last_cyc);
    end

    // R11: auto-precharge burst window, then precharge spacing
    for (int g = 1; g <= BL + TRP; g++) begin
      do_reset;
      step(C_ACT, 0); nops(TRCD - 1); step(C_RD, 0, 1'b1); nops(g - 1); step(C_ACT, 0);
      expect_rec("R11 activate after auto-precharge", (g < BL) ? X_AP : ((g < BL + TRP) ? X_RP : X_NONE), last_cyc);
    end
    do_reset;
    step(C_ACT, 0); nops(TRCD - 1); step(C_WR, 0, 1'b1); step(C_RD, 0);
    expect_rec("R11 column during burst", X_AP, last_cyc);
    do_reset;
    step(C_ACT, 0); nops(TRCD - 1); step(C_WR, 0, 1'b1); nops(BL - 1); step(C_RD, 0);
    expect_rec("R11 bank closed after burst", X_IDLE, last_cyc);

    // R12: refresh run limit
    do_reset;
    for (int k = 0; k < MAXREF; k++) begin step(C_REF); nops(TRFC - 1); end
    expect_rec("R12 full run legal", X_NONE, 0);
    step(C_REF);
    expect_rec("R12 run exceeded", X_RUN, last_cyc);
    do_reset;
    for (int k = 0; k < MAXREF; k++) begin step(C_REF); nops(TRFC - 1); end
    step(C_PRE, 0, 1'b1); nops(TRFC - 1); step(C_REF);
    expect_rec("R12 run broken by other command", X_NONE, 0);

    // R13: state legality
    do_reset;
    step(C_WR, 3);
    expect_rec("R13 write to idle bank", X_IDLE, last_cyc);
    do_reset;
    step(C_ACT, 2); nops(TRC - 1); step(C_ACT, 2);
    expect_rec("R13 activate open bank", X_OPEN, last_cyc);

    // R14: first error kept, lowest bit wins
    do_reset;
    step(C_RD, 1); c0 = last_cyc;
    step(C_ACT, 0); step(C_ACT, 1);
    expect_rec("R14 first error held", X_IDLE, c0);
    do_reset;
    step(C_ACT, 0); nops(TRCD - 1); step(C_RD, 0, 1'b1); step(C_ACT, 0);
    expect_rec("R14 priority of simultaneous rules", X_AP, last_cyc);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule